// File: doc/BRIEF.md
# Configuration Register Integrity Monitor

This block watches a bank of configuration registers for bit changes that nobody intended. Software first writes the registers it needs with checking turned off. It then sets a check-enable input. While that input is high, a scanner visits one register per clock cycle and folds the register's bytes into a running CRC-8. The sum from the first complete pass after enable becomes the reference. Every later pass is compared with that reference when it ends. A difference raises a sticky register-error output.

Registers that change in normal operation, such as conversion results or status words, are removed from the sum through a per-register exclude mask. An excluded register still takes up its scan slot, so a pass always lasts the same number of cycles. The only way to clear the error is to drop check-enable. Enabling again captures a fresh reference, so writes made while checking was off are never flagged.

Top module: `reg_integrity_mon`

## Requirements
- R1: After reset, `reg_err` and `scan_busy` are both 0.
- R2: `scan_busy` is 1 after every clock edge at which `chk_en` is 1, and 0 after every edge at which it is 0.
- R3: The first full pass of NUM_REGS enabled cycles only captures the reference and never raises `reg_err`. A register that changes during that pass, after its slot was scanned, is flagged at the end of the second pass.
- R4: The checksum is CRC-8 with polynomial 0x07 and initial value 0x00, taken MSB first. It covers register 0 to register NUM_REGS-1 in that order, and within each register byte 0 (bits 7:0) comes first. The scan visits register k at the (k+1)-th enabled edge of each pass.
- R5: The exclude mask has one bit per register, with bit k belonging to register k. A register whose bit is 1 adds nothing to the sum, so changes to it never set `reg_err`.
- R6: Once `reg_err` is 1, it stays 1 while `chk_en` stays 1, even if the register returns to its earlier value.
- R7: `reg_err` is 0 after any edge at which `chk_en` is 0. When checking is enabled again, a new reference is captured, so changes made while disabled are not flagged.
- R8: A mismatch at the end of a pass, after the reference has been captured, sets `reg_err` at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Check-enable bit; writes are expected while it is 0 |
| cfg_bank | input | NUM_REGS*REG_W | Flat register bank, register k at bits [k*REG_W +: REG_W] |
| excl_mask | input | NUM_REGS | Bit k set removes register k from the checksum |
| reg_err | output | 1 | Sticky register-error flag |
| scan_busy | output | 1 | 1 while the scanner is walking the bank |

## Verification
The bench first runs a steady bank for several passes, which must stay quiet. It then changes an excluded register, which must also stay quiet. Changes to an included register, first in its low byte and then in its high byte of the last register, show whether every byte and every slot reaches the sum. Restoring a changed value tests whether the flag is sticky. A write made while checking is off, and a write made in the middle of the capture pass, separate re-capture on enable from late detection during the first pass.

// File: rtl/reg_integrity_mon_pkg.sv
package reg_integrity_mon_pkg;

  localparam logic [7:0] CRC_POLY = 8'h07;

  // One byte step of CRC-8, MSB-first, polynomial CRC_POLY.
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] data);
    logic [7:0] x;
    x = crc_in ^ data;
    for (int i = 0; i < 8; i++) begin
      x = x[7] ? ((x << 1) ^ CRC_POLY) : (x << 1);
    end
    return x;
  endfunction

endpackage

// File: rtl/rim_walker.sv
module rim_walker #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  output logic [IDX_W-1:0] idx,
  output logic             pass_end,
  output logic             active
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  assign pass_end = chk_en && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      active <= 1'b0;
    end else if (!chk_en) begin
      idx    <= '0;
      active <= 1'b0;
    end else begin
      active <= 1'b1;
      idx    <= pass_end ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/rim_crc_acc.sv
module rim_crc_acc #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             pass_end,
  input  logic             excluded,
  input  logic [REG_W-1:0] reg_word,
  output logic [7:0]       pass_sum
);
  import reg_integrity_mon_pkg::*;

  localparam int BYTES = REG_W / 8;

  // Fold every byte of one register, byte 0 first.
  function automatic logic [7:0] crc_word(input logic [7:0] c, input logic [REG_W-1:0] w);
    logic [7:0] acc;
    acc = c;
    for (int b = 0; b < BYTES; b++) begin
      acc = crc8_byte(acc, w[8*b +: 8]);
    end
    return acc;
  endfunction

  logic [7:0] crc_q;
  logic [7:0] crc_next;

  assign crc_next = excluded ? crc_q : crc_word(crc_q, reg_word);
  assign pass_sum = crc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= 8'h00;
    else if (!chk_en)   crc_q <= 8'h00;
    else if (pass_end)  crc_q <= 8'h00;
    else                crc_q <= crc_next;
  end
endmodule

// File: rtl/rim_judge.sv
module rim_judge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chk_en,
  input  logic       pass_end,
  input  logic [7:0] pass_sum,
  output logic       ref_valid,
  output logic       mismatch,
  output logic       err
);
  logic [7:0] ref_q;

  assign mismatch = pass_end && ref_valid && (pass_sum != ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= 8'h00;
      ref_valid <= 1'b0;
      err       <= 1'b0;
    end else if (!chk_en) begin
      ref_valid <= 1'b0;
      err       <= 1'b0;
    end else if (pass_end) begin
      if (!ref_valid) begin
        ref_q     <= pass_sum;
        ref_valid <= 1'b1;
      end else if (mismatch) begin
        err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/reg_integrity_mon.sv
module reg_integrity_mon #(
  parameter int NUM_REGS = 6,
  parameter int REG_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chk_en,
  input  logic [NUM_REGS*REG_W-1:0] cfg_bank,
  input  logic [NUM_REGS-1:0]       excl_mask,
  output logic                      reg_err,
  output logic                      scan_busy
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [IDX_W-1:0] idx;
  logic             pass_end;
  logic             ref_valid;
  logic             mismatch;
  logic [7:0]       pass_sum;
  logic [REG_W-1:0] reg_word;
  logic             excluded;

  assign reg_word = cfg_bank[int'(idx)*REG_W +: REG_W];
  assign excluded = excl_mask[idx];

  rim_walker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
    .idx(idx), .pass_end(pass_end), .active(scan_busy)
  );

  rim_crc_acc #(.REG_W(REG_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .pass_end(pass_end),
    .excluded(excluded), .reg_word(reg_word), .pass_sum(pass_sum)
  );

  rim_judge judge_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .pass_end(pass_end),
    .pass_sum(pass_sum), .ref_valid(ref_valid), .mismatch(mismatch), .err(reg_err)
  );
endmodule

// File: rtl/reg_integrity_mon_chk.sv
module reg_integrity_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic chk_en,
  input logic reg_err,
  input logic scan_busy,
  input logic pass_end,
  input logic ref_valid,
  input logic mismatch
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!reg_err && !scan_busy));

  // R2
  busy_on_chk: assert property (@(posedge clk) disable iff (!rst_n) chk_en |=> scan_busy);

  // R2
  busy_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !chk_en |=> !scan_busy);

  // R3
  no_err_before_ref_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(reg_err) |-> $past(ref_valid));

  // R8
  err_at_pass_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(reg_err) |-> $past(pass_end));

  // R8
  mismatch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) mismatch |=> reg_err);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (reg_err && chk_en) |=> reg_err);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n) !chk_en |=> !reg_err);
endmodule

bind reg_integrity_mon reg_integrity_mon_chk chk_i (
  .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .reg_err(reg_err), .scan_busy(scan_busy),
  .pass_end(pass_end), .ref_valid(ref_valid), .mismatch(mismatch)
);

// File: tb/reg_integrity_mon_tb_top.sv
`timescale 1ns/1ps
module reg_integrity_mon_tb_top;
  localparam int N = 6;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           chk_en = 1'b0;
  logic [N*W-1:0] cfg_bank = '0;
  logic [N-1:0]   excl_mask = '0;
  logic           reg_err;
  logic           scan_busy;

  always #2 clk = ~clk;

  reg_integrity_mon #(.NUM_REGS(N), .REG_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .cfg_bank(cfg_bank),
    .excl_mask(excl_mask), .reg_err(reg_err), .scan_busy(scan_busy)
  );

  int    vectors = 0;
  int    fails = 0;
  bit    done = 0;
  string phase_tag = "R1";

  // Behavioural reference model
  logic [7:0] byte_q[$];
  int         slot = 0;
  bit         m_busy = 0, m_err = 0, m_ref_ok = 0;
  logic [7:0] m_ref = 8'h00;

  function automatic logic [7:0] bitwise_crc(input logic [7:0] q[$]);
    logic [7:0] c = 8'h00;
    logic       fb;
    foreach (q[i]) begin
      for (int k = 7; k >= 0; k--) begin
        fb = c[7] ^ q[i][k];
        c  = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [7:0] c;
    if (!rst_n) begin
      byte_q.delete(); slot = 0; m_busy = 0; m_err = 0; m_ref_ok = 0;
    end else if (!chk_en) begin
      byte_q.delete(); slot = 0; m_busy = 0; m_err = 0; m_ref_ok = 0;
    end else begin
      m_busy = 1;
      if (!excl_mask[slot]) begin
        for (int b = 0; b < W/8; b++) byte_q.push_back(cfg_bank[slot*W + 8*b +: 8]);
      end
      if (slot == N-1) begin
        c = bitwise_crc(byte_q);
        if (!m_ref_ok) begin m_ref = c; m_ref_ok = 1; end
        else if (c != m_ref) m_err = 1;
        byte_q.delete();
        slot = 0;
      end else begin
        slot = slot + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (reg_err !== m_err) begin
        fails++;
        $display("FAIL %s reg_err actual=%0b expected=%0b", phase_tag, reg_err, m_err);
      end
      if (scan_busy !== m_busy) begin
        fails++;
        $display("FAIL R2 scan_busy actual=%0b expected=%0b", scan_busy, m_busy);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_reg(input int i, input logic [W-1:0] v);
    cfg_bank[i*W +: W] = v;
  endtask

  initial begin
    run(2);
    check("R1 reg_err in reset", reg_err, 1'b0);
    check("R1 scan_busy in reset", scan_busy, 1'b0);
    rst_n = 1'b1;
    run(1);
    check("R1 reg_err after reset", reg_err, 1'b0);
    check("R1 scan_busy after reset", scan_busy, 1'b0);

    for (int i = 0; i < N; i++) set_reg(i, 16'h1234 + 16'(i * 16'h0F1D));
    excl_mask = 6'b010010;
    phase_tag = "R3";
    chk_en = 1'b1;
    run(1);
    check("R2 busy after enable", scan_busy, 1'b1);
    run(3*N);
    check("R3 steady bank quiet", reg_err, 1'b0);

    phase_tag = "R5";
    set_reg(1, 16'hDEAD);
    set_reg(4, 16'h0001);
    run(3*N);
    check("R5 excluded change ignored", reg_err, 1'b0);

    phase_tag = "R4";
    set_reg(2, cfg_bank[2*W +: W] ^ 16'h0001);
    run(2*N);
    check("R4 low byte change flagged", reg_err, 1'b1);

    phase_tag = "R6";
    set_reg(2, cfg_bank[2*W +: W] ^ 16'h0001);
    run(2*N);
    check("R6 flag sticky after restore", reg_err, 1'b1);

    phase_tag = "R7";
    chk_en = 1'b0;
    run(1);
    check("R7 flag cleared by disable", reg_err, 1'b0);
    check("R2 busy off", scan_busy, 1'b0);
    set_reg(0, 16'hA5A5);
    run(2);
    chk_en = 1'b1;
    run(3*N);
    check("R7 disabled write not flagged", reg_err, 1'b0);

    phase_tag = "R4";
    set_reg(5, cfg_bank[5*W +: W] ^ 16'h8000);
    run(2*N);
    check("R4 high byte of last register flagged", reg_err, 1'b1);

    phase_tag = "R3";
    chk_en = 1'b0;
    run(1);
    chk_en = 1'b1;
    run(2);
    set_reg(0, 16'h0F0F);
    run(N-2);
    check("R3 no flag in capture pass", reg_err, 1'b0);
    run(N);
    check("R3 capture-pass change flagged at pass two", reg_err, 1'b1);

    phase_tag = "R8";
    chk_en = 1'b0;
    run(1);
    excl_mask = 6'b000000;
    chk_en = 1'b1;
    run(2*N);
    set_reg(3, 16'h7777);
    run(2*N);
    check("R8 mismatch with empty mask", reg_err, 1'b1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule